// File: doc/BRIEF.md
# Coprocessor Handshake Follower

This unit sits beside a host processor core as the coprocessor-side tracker for one multi-word coprocessor load/store instruction. It keeps a fetch stage and a decode stage of its own and moves them forward only when the core is visibly fetching and not stalled. An instruction in the decode stage is recognised by its instruction class and coprocessor number fields. When a recognised instruction moves into execute, the unit answers the core's queries on two-bit handshake buses. It first busy-waits for a fixed number of cycles, then streams a fixed number of words, and marks the final one.

The unit commits nothing unless the core's condition-pass line is high. If pass drops, or if a late-cancel arrives in the single cycle where it is honoured, the unit abandons the instruction cleanly. A combiner merges the unit's answers with a second coprocessor's answers, so that both can share the core's handshake inputs. A word counter and a completion pulse make each transfer observable.

Top module: `cop_follower`

## Requirements
- R1: Handshake codes are WAIT = 2'b00, GO = 2'b01, ABSENT = 2'b10, LAST = 2'b11. `hs_exe` is ABSENT whenever no recognised instruction is executing. `hs_dec` is ABSENT whenever the decode stage holds an unrecognised instruction, and also after reset.
- R2: `bus_dec` and `bus_exe` combine the unit's own answer with the peer's answer. Bit 1 is the AND of the two and bit 0 is the OR. A peer answering ABSENT therefore leaves the unit's own code unchanged.
- R3: The fetch and decode stages advance at a rising clock edge only when `fetch_n` is 0 and `run` is 1. In every other cycle `hs_dec` holds its value.
- R4: For a recognised instruction in decode, `hs_dec` is WAIT if BUSY > 0. Otherwise it is LAST if WORDS = 1, and GO in all remaining cases.
- R5: The first execute cycle follows the clock edge at which a recognised decode-stage instruction advances. The unit then answers WAIT for BUSY stepped cycles before any transfer answer.
- R6: After the busy phase, the unit answers GO while two or more words remain and LAST when exactly one remains. One word is counted per stepped cycle that has pass high. One cycle after the LAST cycle, `done` is 1 for exactly one cycle, `words_done` equals WORDS, and `hs_exe` is ABSENT.
- R7: A stepped execute cycle with `pass` = 0 abandons the instruction. `hs_exe` is ABSENT from the next cycle, and `done` does not pulse.
- R8: `cancel` is honoured only in the second stepped execute cycle, where it abandons the instruction as in R7. In any other cycle it has no effect.
- R9: While `run` is 0, the execute state does not advance, so `hs_exe` holds its value.
- R10: An instruction is recognised when bits [27:25] equal 3'b110 and bits [11:8] equal the CP_NUM parameter. The default CP_NUM is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_n | input | 1 | Core instruction-fetch request, low when fetching |
| run | input | 1 | High when the core is not wait-stated |
| instr | input | 32 | Instruction word from the fetch bus |
| pass | input | 1 | Condition pass for the instruction in execute |
| cancel | input | 1 | Late-cancel from the core |
| peer_dec | input | 2 | Decode-stage answer of the other coprocessor |
| peer_exe | input | 2 | Execute-stage answer of the other coprocessor |
| hs_dec | output | 2 | Own decode-stage answer |
| hs_exe | output | 2 | Own execute-stage answer |
| bus_dec | output | 2 | Merged decode-stage answer |
| bus_exe | output | 2 | Merged execute-stage answer |
| words_done | output | $clog2(WORDS+1) | Words transferred by the current or most recent instruction |
| done | output | 1 | One-cycle pulse after a completed transfer |

## Verification
The hardest case to reach is the late-cancel window. It exists in only one stepped cycle, and a stall stretches it in wall-clock time. The stimulus places the recognised instruction in decode with two explicit advances. It then asserts cancel in the first, second and third execute cycles in separate runs, and in one run holds `run` low during the busy phase. The resulting code sequence on `hs_exe` shows that only the second stepped cycle abandons the transfer.

// File: rtl/cop_follower.sv
module cop_follower #(
  parameter logic [3:0] CP_NUM = 4'd5,
  parameter int WORDS = 3,
  parameter int BUSY  = 2,
  localparam int CNT_W = $clog2(WORDS + 1),
  localparam int BSY_W = (BUSY > 0) ? $clog2(BUSY + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_n,
  input  logic             run,
  input  logic [31:0]      instr,
  input  logic             pass,
  input  logic             cancel,
  input  logic [1:0]       peer_dec,
  input  logic [1:0]       peer_exe,
  output logic [1:0]       hs_dec,
  output logic [1:0]       hs_exe,
  output logic [1:0]       bus_dec,
  output logic [1:0]       bus_exe,
  output logic [CNT_W-1:0] words_done,
  output logic             done
);
  localparam logic [1:0] C_WAIT = 2'b00, C_GO = 2'b01, C_ABS = 2'b10, C_LAST = 2'b11;

  logic [31:0]      f_op, d_op;
  logic             active, done_r;
  logic [BSY_W-1:0] bsy;
  logic [CNT_W-1:0] rem, cnt;
  logic [1:0]       age;

  function automatic logic hit(input logic [31:0] op);
    return (op[27:25] == 3'b110) && (op[11:8] == CP_NUM);
  endfunction

  wire       adv       = ~fetch_n & run;
  wire [1:0] first_ans = (BUSY > 0) ? C_WAIT : ((WORDS == 1) ? C_LAST : C_GO);
  wire [1:0] ans       = (bsy != '0) ? C_WAIT : ((rem == CNT_W'(1)) ? C_LAST : C_GO);
  wire       window    = active & (age == 2'd1);
  wire       drop      = active & run & (~pass | (cancel & window));
  wire       xfer      = active & run & ~drop & (bsy == '0);
  wire       fin       = xfer & (rem == CNT_W'(1));
  wire       enter     = adv & hit(d_op) & ~active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_op   <= '0;
      d_op   <= '0;
      active <= 1'b0;
      done_r <= 1'b0;
      bsy    <= '0;
      rem    <= '0;
      cnt    <= '0;
      age    <= '0;
    end else begin
      if (adv) begin
        f_op <= instr;
        d_op <= f_op;
      end
      done_r <= fin;
      if (enter) begin
        active <= 1'b1;
        bsy    <= BSY_W'(BUSY);
        rem    <= CNT_W'(WORDS);
        cnt    <= '0;
        age    <= '0;
      end else if (drop | fin) begin
        active <= 1'b0;
        if (fin) cnt <= cnt + 1'b1;
      end else if (active & run) begin
        if (bsy != '0) bsy <= bsy - 1'b1;
        else begin
          rem <= rem - 1'b1;
          cnt <= cnt + 1'b1;
        end
        if (age != 2'd2) age <= age + 1'b1;
      end
    end
  end

  assign hs_dec     = hit(d_op) ? first_ans : C_ABS;
  assign hs_exe     = active ? ans : C_ABS;
  assign bus_dec    = {hs_dec[1] & peer_dec[1], hs_dec[0] | peer_dec[0]};
  assign bus_exe    = {hs_exe[1] & peer_exe[1], hs_exe[0] | peer_exe[0]};
  assign words_done = cnt;
  assign done       = done_r;
endmodule

module cop_follower_chk #(
  parameter int WORDS = 3,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_n,
  input logic             run,
  input logic             pass,
  input logic [1:0]       peer_exe,
  input logic [1:0]       hs_dec,
  input logic [1:0]       hs_exe,
  input logic [1:0]       bus_exe,
  input logic [CNT_W-1:0] words_done,
  input logic             done
);
  // R2
  merge_absent_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_exe == 2'b10) |-> (bus_exe == hs_exe));
  // R3
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fetch_n && run) |=> $stable(hs_dec));
  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(hs_exe) == 2'b11 && words_done == CNT_W'(WORDS)));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  pass_low_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_exe != 2'b10 && run && !pass) |=> (hs_exe == 2'b10 && !done));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_exe != 2'b10 && !run) |=> $stable(hs_exe));
endmodule

bind cop_follower cop_follower_chk #(.WORDS(WORDS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_n(fetch_n), .run(run), .pass(pass),
  .peer_exe(peer_exe), .hs_dec(hs_dec), .hs_exe(hs_exe), .bus_exe(bus_exe),
  .words_done(words_done), .done(done)
);

// File: tb/cop_follower_tb.sv
module cop_follower_tb;
  localparam logic [1:0] W = 2'b00, G = 2'b01, A = 2'b10, L = 2'b11;
  localparam logic [31:0] OP5  = 32'hEC00_0500;
  localparam logic [31:0] OP6  = 32'hEC00_0600;
  localparam logic [31:0] OPBD = 32'hEE00_0500;

  logic clk = 0, rst_n = 0, fetch_n = 1, run = 1, pass = 1, cancel = 0;
  logic [31:0] instr = '0;
  logic [1:0] peer_dec = A, peer_exe = A;
  logic [1:0] hs_dec, hs_exe, bus_dec, bus_exe;
  logic [1:0] words_done;
  logic done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cop_follower u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_n(fetch_n), .run(run), .instr(instr),
    .pass(pass), .cancel(cancel), .peer_dec(peer_dec), .peer_exe(peer_exe),
    .hs_dec(hs_dec), .hs_exe(hs_exe), .bus_dec(bus_dec), .bus_exe(bus_exe),
    .words_done(words_done), .done(done)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step(input logic fn, input logic rn, input logic ps, input logic cn,
                      input logic [1:0] ex, input string r);
    @(posedge clk); #1;
    fetch_n = fn; run = rn; pass = ps; cancel = cn;
    exp_q.push_back(ex);
    tag_q.push_back(r);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, hs_exe, e);
    end
  end

  task automatic load(input logic [31:0] op);
    step(0, 1, 1, 0, A, "R1");
    instr = op;
    step(0, 1, 1, 0, A, "R1");
    instr = '0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1", hs_exe, A);
    chk("R1", hs_dec, A);
    chk("R6", done, 0);

    // R2 merge with own idle
    peer_dec = W; #1 chk("R2", bus_dec, W);
    peer_dec = L; #1 chk("R2", bus_dec, L);
    peer_dec = A;

    // Normal transfer: R4 R5 R6 R10
    load(OP5);
    step(0, 1, 1, 0, A, "R5");
    chk("R4", hs_dec, W);
    peer_dec = G; #1 chk("R2", bus_dec, G); peer_dec = A;
    step(1, 1, 1, 0, W, "R5");
    step(1, 1, 1, 0, W, "R5");
    step(1, 1, 1, 0, G, "R6");
    chk("R2", bus_exe, G);
    step(1, 1, 1, 0, G, "R6");
    step(1, 1, 1, 0, L, "R6");
    step(1, 1, 1, 0, A, "R6");
    chk("R6", done, 1);
    chk("R6", words_done, 3);
    step(1, 1, 1, 0, A, "R6");
    chk("R6", done, 0);

    // Pipeline hold R3, execute stall R9
    load(OP5);
    step(1, 1, 1, 0, A, "R3");
    chk("R3", hs_dec, W);
    step(0, 0, 1, 0, A, "R3");
    chk("R3", hs_dec, W);
    step(0, 1, 1, 0, A, "R3");
    chk("R3", hs_dec, W);
    step(1, 1, 1, 0, W, "R5");
    step(1, 0, 1, 0, W, "R9");
    step(1, 1, 1, 0, W, "R9");
    step(1, 1, 1, 0, G, "R9");
    step(1, 1, 1, 0, G, "R6");
    step(1, 1, 1, 0, L, "R6");
    step(1, 1, 1, 0, A, "R6");
    chk("R9", done, 1);

    // Pass low abandons R7
    load(OP5);
    step(0, 1, 1, 0, A, "R7");
    step(1, 1, 1, 0, W, "R7");
    step(1, 1, 0, 0, W, "R7");
    step(1, 1, 1, 0, A, "R7");
    chk("R7", done, 0);
    step(1, 1, 1, 0, A, "R7");
    chk("R7", done, 0);
    chk("R7", words_done, 0);

    // Cancel in second execute cycle R8
    load(OP5);
    step(0, 1, 1, 0, A, "R8");
    step(1, 1, 1, 1, W, "R8");
    step(1, 1, 1, 1, W, "R8");
    step(1, 1, 1, 0, A, "R8");
    step(1, 1, 1, 0, A, "R8");
    chk("R8", done, 0);

    // Cancel outside window ignored R8
    load(OP5);
    step(0, 1, 1, 0, A, "R8");
    step(1, 1, 1, 1, W, "R8");
    step(1, 1, 1, 0, W, "R8");
    step(1, 1, 1, 1, G, "R8");
    step(1, 1, 1, 0, G, "R8");
    step(1, 1, 1, 0, L, "R8");
    step(1, 1, 1, 0, A, "R8");
    chk("R8", done, 1);
    chk("R8", words_done, 3);

    // Non-matching coprocessor number and class R10 R1
    load(OP6);
    step(0, 1, 1, 0, A, "R10");
    chk("R10", hs_dec, A);
    step(1, 1, 1, 0, A, "R10");
    step(1, 1, 1, 0, A, "R10");
    load(OPBD);
    step(0, 1, 1, 0, A, "R10");
    chk("R10", hs_dec, A);
    step(1, 1, 1, 0, A, "R1");
    step(1, 1, 1, 0, A, "R1");
    chk("R1", done, 0);

    repeat (3) @(posedge clk);
    #3 finish_run();
  end
endmodule